// File: doc/BRIEF.md
# Multicycle Processor Core for a Small 32-bit RISC Subset

This core runs a reduced 32-bit load/store instruction set: register-to-register arithmetic and logic, word load, word store and branch-on-equal. It has one memory port, and that port serves both instruction fetch and data access. Each instruction therefore runs as a sequence of short clock steps instead of one long cycle. A control state machine walks through fetch, decode, execute, memory and writeback. Internal holding registers keep the instruction, the two source operands, the ALU result and the loaded word from one step to the next.

The memory attached to the port must return read data combinationally for the address presented, and must commit a write at the rising clock edge while the write enable is high. Addresses are byte addresses, and only aligned words are accessed. The instruction formats follow the common three-register and register-immediate layouts. The opcode is in bits 31:26, the source registers are in bits 25:21 and 20:16, the destination register is in bits 15:11, the function code is in bits 5:0 and the 16-bit offset is in bits 15:0.

Top module: `mc_core`

## Requirements
- R1: While rst_ni is low, the program counter is 0 and the controller is in the fetch step. During reset, mem_addr_o reads 0 and mem_we_o is 0.
- R2: Every instruction starts with a fetch step. In that step mem_addr_o equals the program counter, the word read is captured as the instruction, and the program counter advances by 4.
- R3: The step count depends on the instruction. Register-to-register takes 4 steps, load takes 5, store takes 4 and branch-on-equal takes 3. The next fetch follows directly.
- R4: Register-to-register instructions use opcode 0. The function code selects the operation: 0x20 adds, 0x22 subtracts, 0x24 is AND, 0x25 is OR, and 0x2a gives 1 when rs is less than rt as signed values and 0 otherwise. The result is written to rd in step 4.
- R5: Load (opcode 0x23) reads the word at rs plus the sign-extended offset in step 4 and writes it to rt in step 5.
- R6: Store (opcode 0x2b) drives mem_addr_o with rs plus the sign-extended offset and mem_wdata_o with rt in step 4. In that step mem_we_o is high for exactly one cycle.
- R7: Branch-on-equal (opcode 0x04) compares rs and rt. If they are equal, the program counter becomes the fetch address plus 4 plus the sign-extended offset shifted left by 2. If they differ, the program counter becomes the fetch address plus 4. Backward offsets are allowed.
- R8: Register 0 always reads as zero, and writes to register 0 have no effect.
- R9: mem_we_o is high only in the memory step of a store. In that step mem_addr_o comes from the ALU result register. In the fetch step it comes from the program counter.
- R10: An unsupported opcode takes 2 steps (fetch and decode). It changes no register and no memory location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 32 | Byte address for fetch or data access |
| mem_wdata_o | output | 32 | Store data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 32 | Combinational read data for mem_addr_o |

## Verification
The bench holds a reference instruction model and knows the step count of every instruction. It therefore knows the cycle of each fetch and samples the fetch address exactly there. Step 0 of the next instruction falls 3, 4, 5 or 2 cycles after the current fetch, depending on the instruction class. The store address, store data and write enable are due in step 3 counted from the fetch, and the load address is due in the same step. Every other cycle is checked for a low write enable. All samples are taken at the falling clock edge, half a period after the registers settle. Register contents are only visible through the store port. A final sequence of stores copies all 32 registers into memory, and each store's data is compared with the model.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned ILEN = 32;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB
  } state_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef enum logic [1:0] {
    SRCB_REG, SRCB_FOUR, SRCB_IMM, SRCB_IMM_SH
  } srcb_e;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2b;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2a;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  logic [W-1:0] diff;
  assign diff = a_i - b_i;

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = diff;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter  int unsigned NREGS = 32,
  parameter  int unsigned W     = 32,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i
);
  logic [W-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i) begin
        if (we_i && waddr_i == AW'(g)) regs[g] <= wdata_i;
      end
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];

  // R8: register zero never returns anything but zero
  p_zero_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o == '0));
  p_zero_read_b_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_b_i == '0) |-> (rdata_b_o == '0));
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  input  logic    zero_i,
  output state_e  state_o,
  output logic    ir_we_o,
  output logic    pc_we_o,
  output logic    pc_from_reg_o,
  output logic    ab_we_o,
  output logic    res_we_o,
  output logic    mdr_we_o,
  output logic    rf_we_o,
  output logic    rf_dst_rd_o,
  output logic    rf_from_mdr_o,
  output logic    mem_data_o,
  output logic    mem_we_o,
  output logic    srca_pc_o,
  output srcb_e   srcb_o,
  output alu_op_e alu_op_o
);
  state_e state_q, state_d;
  logic   is_r, is_lw, is_sw, is_beq, known;

  assign is_r   = (opcode_i == OP_RTYPE);
  assign is_lw  = (opcode_i == OP_LW);
  assign is_sw  = (opcode_i == OP_SW);
  assign is_beq = (opcode_i == OP_BEQ);
  assign known  = is_r | is_lw | is_sw | is_beq;

  function automatic alu_op_e fn_decode(input logic [5:0] fn);
    unique case (fn)
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      FN_SLT:  return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = known ? ST_EXEC : ST_FETCH;
      ST_EXEC:   state_d = is_beq ? ST_FETCH : ST_MEM;
      ST_MEM:    state_d = is_lw ? ST_WB : ST_FETCH;
      ST_WB:     state_d = ST_FETCH;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    ir_we_o       = 1'b0;
    pc_we_o       = 1'b0;
    pc_from_reg_o = 1'b0;
    ab_we_o       = 1'b0;
    res_we_o      = 1'b0;
    mdr_we_o      = 1'b0;
    rf_we_o       = 1'b0;
    rf_dst_rd_o   = 1'b0;
    rf_from_mdr_o = 1'b0;
    mem_data_o    = 1'b0;
    mem_we_o      = 1'b0;
    srca_pc_o     = 1'b0;
    srcb_o        = SRCB_REG;
    alu_op_o      = ALU_ADD;
    unique case (state_q)
      ST_FETCH: begin
        ir_we_o   = 1'b1;
        pc_we_o   = 1'b1;
        srca_pc_o = 1'b1;
        srcb_o    = SRCB_FOUR;
      end
      ST_DECODE: begin
        // branch target precomputed while operands are read
        ab_we_o   = 1'b1;
        res_we_o  = 1'b1;
        srca_pc_o = 1'b1;
        srcb_o    = SRCB_IMM_SH;
      end
      ST_EXEC: begin
        if (is_beq) begin
          alu_op_o      = ALU_SUB;
          pc_we_o       = zero_i;
          pc_from_reg_o = 1'b1;
        end else if (is_r) begin
          alu_op_o = fn_decode(funct_i);
          res_we_o = 1'b1;
        end else begin
          srcb_o   = SRCB_IMM;
          res_we_o = 1'b1;
        end
      end
      ST_MEM: begin
        if (is_r) begin
          rf_we_o     = 1'b1;
          rf_dst_rd_o = 1'b1;
        end else begin
          mem_data_o = 1'b1;
          mdr_we_o   = is_lw;
          mem_we_o   = is_sw;
        end
      end
      ST_WB: begin
        rf_we_o       = 1'b1;
        rf_from_mdr_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign state_o = state_q;

  // R3: step sequencing
  p_fetch_then_decode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE));
  p_wb_only_after_mem_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB) |=> (state_q == ST_FETCH));
  p_beq_three_steps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && is_beq) |=> (state_q == ST_FETCH));
  p_unknown_two_steps_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECODE && !known) |=> (state_q == ST_FETCH));
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter  int unsigned XLEN  = 32,
  parameter  int unsigned NREGS = 32,
  localparam int unsigned RAW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            mem_we_o,
  input  logic [XLEN-1:0] mem_rdata_i
);
  logic [XLEN-1:0] pc_q, res_q, a_q, b_q, mdr_q;
  logic [ILEN-1:0] ir_q;
  state_e  state;
  alu_op_e alu_op;
  srcb_e   srcb;
  logic ir_we, pc_we, pc_from_reg, ab_we, res_we, mdr_we;
  logic rf_we, rf_dst_rd, rf_from_mdr, mem_data, srca_pc, zero;
  logic [XLEN-1:0] rf_a, rf_b, alu_a, alu_b, alu_y, imm_ext, rf_wdata;
  logic [RAW-1:0]  rf_waddr;

  mc_ctrl i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .opcode_i      (ir_q[31:26]),
    .funct_i       (ir_q[5:0]),
    .zero_i        (zero),
    .state_o       (state),
    .ir_we_o       (ir_we),
    .pc_we_o       (pc_we),
    .pc_from_reg_o (pc_from_reg),
    .ab_we_o       (ab_we),
    .res_we_o      (res_we),
    .mdr_we_o      (mdr_we),
    .rf_we_o       (rf_we),
    .rf_dst_rd_o   (rf_dst_rd),
    .rf_from_mdr_o (rf_from_mdr),
    .mem_data_o    (mem_data),
    .mem_we_o      (mem_we_o),
    .srca_pc_o     (srca_pc),
    .srcb_o        (srcb),
    .alu_op_o      (alu_op)
  );

  assign imm_ext  = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign rf_waddr = rf_dst_rd ? ir_q[11+:RAW] : ir_q[16+:RAW];
  assign rf_wdata = rf_from_mdr ? mdr_q : res_q;

  mc_regfile #(.NREGS(NREGS), .W(XLEN)) i_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raddr_a_i (ir_q[21+:RAW]),
    .raddr_b_i (ir_q[16+:RAW]),
    .rdata_a_o (rf_a),
    .rdata_b_o (rf_b),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata)
  );

  assign alu_a = srca_pc ? pc_q : a_q;
  always_comb begin
    unique case (srcb)
      SRCB_REG:    alu_b = b_q;
      SRCB_FOUR:   alu_b = XLEN'(4);
      SRCB_IMM:    alu_b = imm_ext;
      SRCB_IMM_SH: alu_b = {imm_ext[XLEN-3:0], 2'b00};
      default:     alu_b = b_q;
    endcase
  end

  mc_alu #(.W(XLEN)) i_alu (
    .a_i    (alu_a),
    .b_i    (alu_b),
    .op_i   (alu_op),
    .y_o    (alu_y),
    .zero_o (zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      mdr_q <= '0;
    end else begin
      if (pc_we)  pc_q  <= pc_from_reg ? res_q : alu_y;
      if (ir_we)  ir_q  <= mem_rdata_i;
      if (ab_we)  begin a_q <= rf_a; b_q <= rf_b; end
      if (res_we) res_q <= alu_y;
      if (mdr_we) mdr_q <= mem_rdata_i;
    end
  end

  assign mem_addr_o  = mem_data ? res_q : pc_q;
  assign mem_wdata_o = b_q;

  // R2: fetch address and PC advance
  p_fetch_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FETCH) |-> (mem_addr_o == pc_q));
  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FETCH) |=> (pc_q == $past(pc_q) + XLEN'(4)));
  // R7: PC only changes in fetch or branch execute
  p_pc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DECODE || state == ST_MEM || state == ST_WB) |=> $stable(pc_q));
  // R6: write strobe is one cycle, addressed by the ALU result
  p_we_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == res_q && mem_wdata_o == b_q));
  p_we_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  // R9: never write during fetch
  p_no_we_fetch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FETCH) |-> !mem_we_o);
endmodule

// File: tb/test_mc_core.sv
module test_mc_core;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW = 256;

  logic        clk, rst_ni;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [31:0] mem [MEMW];
  logic [31:0] ref_mem [MEMW];
  logic [31:0] ref_rf [32];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  mc_core i_mc_core (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .mem_rdata_i(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] ref_alu(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2a:   return {31'd0, $signed(a) < $signed(b)};
      default: return a + b;
    endcase
  endfunction
  function automatic int wr_reg();
    int r = int'($urandom % 32);
    return (r == 30) ? 29 : r;
  endfunction

  logic [31:0] pc;
  int          loop_hits;

  task automatic run_instr();
    logic [31:0] w, a, b, imm, ea;
    logic [5:0]  op;
    int rs, rt, rd, n;
    w   = ref_mem[pc[9:2]];
    op  = w[31:26]; rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
    imm = {{16{w[15]}}, w[15:0]};
    a   = ref_rf[rs]; b = ref_rf[rt];
    ea  = a + imm;
    // R3: per-class step count, R10: unsupported opcode
    case (op)
      6'h00: n = 4;
      6'h23: n = 5;
      6'h2b: n = 4;
      6'h04: n = 3;
      default: n = 2;
    endcase
    for (int k = 0; k < n; k++) begin
      if (k == 0) begin
        chk("R2 R3 fetch address", mem_addr, pc);
        chk("R9 no write in fetch", {31'd0, mem_we}, 32'd0);
      end else if (k == 3 && op == 6'h2b) begin
        chk("R6 store address", mem_addr, ea);
        chk("R6 R4 R5 R8 store data", mem_wdata, b);
        chk("R6 store strobe", {31'd0, mem_we}, 32'd1);
      end else if (k == 3 && op == 6'h23) begin
        chk("R5 load address", mem_addr, ea);
        chk("R9 no write in load", {31'd0, mem_we}, 32'd0);
      end else begin
        chk("R9 write idle", {31'd0, mem_we}, 32'd0);
      end
      @(negedge clk); #1;
    end
    pc = pc + 32'd4;
    case (op)
      6'h00: if (rd != 0) ref_rf[rd] = ref_alu(w[5:0], a, b);
      6'h23: if (rt != 0) ref_rf[rt] = ref_mem[ea[9:2]];
      6'h2b: ref_mem[ea[9:2]] = b;
      6'h04: if (a == b) pc = pc + {imm[29:0], 2'b00};
      default: ;
    endcase
  endtask

  initial begin
    logic [31:0] prog [MEMW];
    logic [5:0]  fns [5];
    int p, seed;
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2a;
    seed = int'($urandom(32'h00C0FFEE));
    for (int i = 0; i < MEMW; i++) prog[i] = $urandom;
    for (int i = 0; i < 32; i++) ref_rf[i] = 32'd0;
    prog[222] = 32'h0000_0300;          // base for r30
    prog[200] = 32'h8000_0000;          // negative value for slt
    // initial loads r1..r31 from words 193..223
    p = 0;
    for (int i = 1; i < 32; i++) prog[p++] = enc_i(6'h23, 0, i, 32'h200 + 4*(64+i));
    prog[p++] = {6'h3f, 26'h155_5555};  // R10 unsupported opcode
    for (int i = 0; i < 60; i++) begin
      int kind = int'($urandom % 8);
      int rs = int'($urandom % 32);
      int rt = int'($urandom % 32);
      if (i >= 56) kind = 0;
      case (kind)
        0, 1, 2: prog[p++] = enc_r(rs, rt, wr_reg(), fns[$urandom % 5]);
        3: prog[p++] = enc_i(6'h23, 30, wr_reg(), int'($urandom % 128)*4 - 32'h100);
        4: prog[p++] = enc_i(6'h2b, 30, rt, int'($urandom % 128)*4 - 32'h100);
        5: prog[p++] = enc_i(6'h2b, 0, rt, 32'h200 + int'($urandom % 128)*4);
        default: begin
          if ($urandom % 2 == 1) rt = rs;
          prog[p++] = enc_i(6'h04, rs, rt, int'($urandom % 4));
        end
      endcase
    end
    // directed: write to r0, then dump
    prog[p-1] = enc_r(5, 6, 0, 6'h25);  // R8 write to r0 ignored
    for (int i = 0; i < 32; i++) prog[p++] = enc_i(6'h2b, 0, i, 32'h200 + 4*i);
    prog[p] = enc_i(6'h04, 0, 0, 32'hFFFF); // R7 backward branch to self
    for (int i = 0; i < MEMW; i++) begin mem[i] = prog[i]; ref_mem[i] = prog[i]; end

    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset address", mem_addr, 32'd0);
    chk("R1 reset strobe", {31'd0, mem_we}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    pc = 32'd0;
    loop_hits = 0;
    for (int s = 0; s < 600 && loop_hits < 8; s++) begin
      if (pc == 32'(4*p)) loop_hits++;
      run_instr();
    end
    chk("R7 reached final loop", 32'(loop_hits), 32'd8);
    summary();
  end
endmodule